// File: doc/BRIEF.md
# Binary Trie Longest-Prefix-Match Engine

This block resolves a 32-bit destination address to a next-hop index by longest-prefix match. The routing table lives on chip as a binary trie. Each node holds a left and a right child pointer, a prefix-present mark and a next-hop value. A node stores no bit string, because its position in the trie defines its prefix. A lookup starts at the root and reads one address bit per cycle, most significant bit first. A 0 bit goes to the left child and a 1 bit goes to the right child. The engine records the next hop of the deepest marked node it has passed. The walk stops when the needed child does not exist, or when all 32 bits have been used.

A host builds the table through the update port. An insert follows the prefix bits, takes fresh nodes from a free counter wherever the path ends early, and then marks the last node with its next hop. A delete follows the same path and clears the mark on the last node. It never frees nodes. The engine runs one operation at a time. Lookup requests and results both use valid/ready handshakes. While `res_valid` is high and `res_ready` is low, the result stays frozen and no new request is accepted. That back-pressure reaches all the way back to `lk_ready`.

Top module: `trie_lpm_engine`

## Requirements
- R1: After reset, `lk_ready` and `upd_ready` are 1, `res_valid` and `upd_done` are 0, and the table is empty, so every lookup misses.
- R2: A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. Once it is accepted, both ready outputs stay low until the result has been taken. `res_valid`, `res_hit` and `res_nh` hold steady while `res_ready` is low. When both request valids are high in the same idle cycle, the update wins and `lk_ready` is 0.
- R3: A lookup returns `res_hit`=1 together with the next hop of the longest stored prefix whose bits equal the leading bits of `lk_addr`. Matching starts at bit 31, and a bit value of 0 selects the left branch.
- R4: When no stored prefix matches, `res_hit` is 0 and `res_nh` is 0.
- R5: An insert has `upd_op`=0. It stores the top `upd_len` bits of `upd_prefix`, where `upd_len` ranges from 0 to 32, with the next hop `upd_nh`. A length of 0 marks the root, which acts as a default route. Inserting the same prefix again replaces its next hop.
- R6: A delete has `upd_op`=1. It removes only the given prefix, so longer prefixes beneath it still match. Deleting a prefix that is not stored changes no lookup result.
- R7: A /32 prefix is matched at full depth. The walk ends after 32 bits even if the node reached still has children.
- R8: The node array holds the root plus NODES-1 allocated nodes. An insert that needs a node when none is free raises `upd_err` together with `upd_done`. That prefix does not become matchable, and prefixes stored earlier keep their results.
- R9: Let d be the depth of the deepest node that exists along the address path, with d at most 32. `res_valid` rises d+1 cycles after the accepting edge. An insert that does not overflow raises `upd_done` `upd_len`+1 cycles after its accepting edge.
- R10: `upd_done` is high for exactly one cycle per update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Engine can take a lookup |
| lk_addr | input | KEY_W | Address to resolve |
| res_valid | output | 1 | Lookup result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | A stored prefix matched |
| res_nh | output | NH_W | Next hop of the longest match, 0 on miss |
| upd_valid | input | 1 | Table update request valid |
| upd_ready | output | 1 | Engine can take an update |
| upd_op | input | 1 | 0 insert, 1 delete |
| upd_prefix | input | KEY_W | Prefix, aligned to the most significant bit |
| upd_len | input | DEP_W | Prefix length, 0 to KEY_W |
| upd_nh | input | NH_W | Next hop for an insert |
| upd_done | output | 1 | One-cycle pulse when an update finishes |
| upd_err | output | 1 | Insert ran out of nodes (only with upd_done) |

## Verification
A lookup result appears d+1 cycles after acceptance, where d is the depth walked. The bench counts clock edges from the accepting edge until `res_valid` is high, sampling on the falling edge, and compares the count with d+1. It does this for an empty table (1 cycle) and for a full 32-bit path (33 cycles). An update finishes after `upd_len`+1 cycles, and an overflow ends at the depth where allocation failed. The bench checks both counts the same way and then verifies that `upd_done` is low again one cycle later. For the stall checks, `res_ready` is held low for several cycles, and the result and both ready outputs are sampled on each of those cycles.

// File: rtl/trie_lpm_pkg.sv
package trie_lpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LWALK = 2'd1,
    ST_LRES  = 2'd2,
    ST_UWALK = 2'd3
  } eng_state_e;

  localparam logic OP_INSERT = 1'b0;
  localparam logic OP_DELETE = 1'b1;
endpackage

// File: rtl/trie_node_mem.sv
// Node array: combinational read, one synchronous write port.
// Pointer value 0 means "no child" because the root is never a child.
module trie_node_mem #(
  parameter int NODES = 64,
  parameter int PTR_W = 6,
  parameter int NH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [PTR_W-1:0] rd_left,
  output logic [PTR_W-1:0] rd_right,
  output logic             rd_mark,
  output logic [NH_W-1:0]  rd_nh,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [PTR_W-1:0] wr_left,
  input  logic [PTR_W-1:0] wr_right,
  input  logic             wr_mark,
  input  logic [NH_W-1:0]  wr_nh
);
  logic [PTR_W-1:0] left_q  [NODES];
  logic [PTR_W-1:0] right_q [NODES];
  logic             mark_q  [NODES];
  logic [NH_W-1:0]  nh_q    [NODES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) begin
        left_q[i]  <= '0;
        right_q[i] <= '0;
        mark_q[i]  <= 1'b0;
        nh_q[i]    <= '0;
      end
    end else if (wr_en) begin
      left_q[wr_addr]  <= wr_left;
      right_q[wr_addr] <= wr_right;
      mark_q[wr_addr]  <= wr_mark;
      nh_q[wr_addr]    <= wr_nh;
    end
  end

  assign rd_left  = left_q[rd_addr];
  assign rd_right = right_q[rd_addr];
  assign rd_mark  = mark_q[rd_addr];
  assign rd_nh    = nh_q[rd_addr];
endmodule

// File: rtl/trie_node_alloc.sv
// Bump allocator: node 0 is the root, so the first free node is 1.
module trie_node_alloc #(
  parameter int NODES = 64,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  output logic [PTR_W-1:0] next_ptr,
  output logic             full
);
  localparam int CNT_W = PTR_W + 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= CNT_W'(1);
    else if (take && !full) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign full     = (cnt_q == CNT_W'(NODES));
  assign next_ptr = cnt_q[PTR_W-1:0];
endmodule

// File: rtl/trie_best_reg.sv
// Running best-match register for one lookup walk.
module trie_best_reg #(
  parameter int NH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [NH_W-1:0] nh_in,
  output logic            hit,
  output logic [NH_W-1:0] nh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit <= 1'b0;
      nh  <= '0;
    end else if (clr) begin
      hit <= 1'b0;
      nh  <= '0;
    end else if (load) begin
      hit <= 1'b1;
      nh  <= nh_in;
    end
  end
endmodule

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine
  import trie_lpm_pkg::*;
#(
  parameter int  KEY_W = 32,
  parameter int  NH_W  = 8,
  parameter int  NODES = 64,
  localparam int DEP_W = $clog2(KEY_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [KEY_W-1:0] lk_addr,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_hit,
  output logic [NH_W-1:0]  res_nh,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic             upd_op,
  input  logic [KEY_W-1:0] upd_prefix,
  input  logic [DEP_W-1:0] upd_len,
  input  logic [NH_W-1:0]  upd_nh,
  output logic             upd_done,
  output logic             upd_err
);
  localparam int PTR_W = $clog2(NODES);

  eng_state_e       state_q;
  logic [PTR_W-1:0] cur_q;
  logic [DEP_W-1:0] depth_q;
  logic [KEY_W-1:0] key_q;
  logic             op_q;
  logic [DEP_W-1:0] len_q;
  logic [NH_W-1:0]  nh_q;
  logic             done_q, err_q;

  logic [PTR_W-1:0] rd_left, rd_right;
  logic             rd_mark;
  logic [NH_W-1:0]  rd_nh;
  logic             wr_en, wr_mark;
  logic [PTR_W-1:0] wr_left, wr_right;
  logic [NH_W-1:0]  wr_nh;
  logic [PTR_W-1:0] free_ptr;
  logic             pool_full, take;
  logic             best_clr, best_load;

  logic             key_bit, child_none, key_end, len_end;
  logic [PTR_W-1:0] child;
  logic             lk_go, upd_go;

  assign key_bit    = key_q[KEY_W-1];
  assign child      = key_bit ? rd_right : rd_left;
  assign child_none = (child == '0);
  assign key_end    = (depth_q == DEP_W'(KEY_W));
  assign len_end    = (depth_q == len_q);

  assign upd_ready = (state_q == ST_IDLE);
  assign lk_ready  = (state_q == ST_IDLE) && !upd_valid;
  assign upd_go    = upd_valid && upd_ready;
  assign lk_go     = lk_valid && lk_ready;
  assign res_valid = (state_q == ST_LRES);
  assign upd_done  = done_q;
  assign upd_err   = err_q;

  trie_node_mem #(.NODES(NODES), .PTR_W(PTR_W), .NH_W(NH_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(cur_q), .rd_left(rd_left), .rd_right(rd_right),
    .rd_mark(rd_mark), .rd_nh(rd_nh),
    .wr_en(wr_en), .wr_addr(cur_q), .wr_left(wr_left), .wr_right(wr_right),
    .wr_mark(wr_mark), .wr_nh(wr_nh)
  );

  trie_node_alloc #(.NODES(NODES), .PTR_W(PTR_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .take(take),
    .next_ptr(free_ptr), .full(pool_full)
  );

  trie_best_reg #(.NH_W(NH_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(best_clr), .load(best_load),
    .nh_in(rd_nh), .hit(res_hit), .nh(res_nh)
  );

  // Memory write, allocation and best-match control
  always_comb begin
    wr_en     = 1'b0;
    wr_left   = rd_left;
    wr_right  = rd_right;
    wr_mark   = rd_mark;
    wr_nh     = rd_nh;
    take      = 1'b0;
    best_clr  = lk_go;
    best_load = 1'b0;
    unique case (state_q)
      ST_LWALK: best_load = rd_mark;
      ST_UWALK: begin
        if (len_end) begin
          wr_en = 1'b1;
          if (op_q == OP_INSERT) begin
            wr_mark = 1'b1;
            wr_nh   = nh_q;
          end else begin
            wr_mark = 1'b0;
          end
        end else if (child_none && op_q == OP_INSERT && !pool_full) begin
          wr_en = 1'b1;
          take  = 1'b1;
          if (key_bit) wr_right = free_ptr;
          else         wr_left  = free_ptr;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      depth_q <= '0;
      key_q   <= '0;
      op_q    <= OP_INSERT;
      len_q   <= '0;
      nh_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cur_q   <= '0;
          depth_q <= '0;
          if (upd_go) begin
            state_q <= ST_UWALK;
            key_q   <= upd_prefix;
            op_q    <= upd_op;
            len_q   <= (upd_len > DEP_W'(KEY_W)) ? DEP_W'(KEY_W) : upd_len;
            nh_q    <= upd_nh;
          end else if (lk_go) begin
            state_q <= ST_LWALK;
            key_q   <= lk_addr;
          end
        end
        ST_LWALK: begin
          if (key_end || child_none) begin
            state_q <= ST_LRES;
          end else begin
            cur_q   <= child;
            depth_q <= depth_q + DEP_W'(1);
            key_q   <= key_q << 1;
          end
        end
        ST_LRES: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        ST_UWALK: begin
          if (len_end) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (!child_none) begin
            cur_q   <= child;
            depth_q <= depth_q + DEP_W'(1);
            key_q   <= key_q << 1;
          end else if (op_q == OP_DELETE) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (pool_full) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cur_q   <= free_ptr;
            depth_q <= depth_q + DEP_W'(1);
            key_q   <= key_q << 1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk #(
  parameter int NH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic            upd_valid,
  input logic            upd_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_hit,
  input logic [NH_W-1:0] res_nh,
  input logic            upd_done,
  input logic            upd_err
);
  // R2
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_nh));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !lk_ready && !upd_ready);

  // R2
  upd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_ready |=> !upd_ready && !lk_ready);

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_nh == '0);

  // R8
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_err |-> upd_done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R2
  lk_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> !res_valid || !lk_ready);
endmodule

bind trie_lpm_engine trie_lpm_chk #(.NH_W(NH_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .upd_valid(upd_valid), .upd_ready(upd_ready),
  .res_valid(res_valid), .res_ready(res_ready),
  .res_hit(res_hit), .res_nh(res_nh),
  .upd_done(upd_done), .upd_err(upd_err)
);

// File: tb/test_trie_lpm_engine.sv
module test_trie_lpm_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int KEY_W = 32;
  localparam int NH_W  = 8;
  localparam int DEP_W = 6;

  localparam logic [1:0] K_INS = 2'd0, K_DEL = 2'd1, K_LK = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [5:0]  len;
    logic [7:0]  nh;
    logic        ehit;
    logic [7:0]  enh;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{K_INS, 32'h0A000000,  6'd8, 8'h01, 1'b0, 8'h00},
    '{K_INS, 32'h0A010000, 6'd16, 8'h02, 1'b0, 8'h00},
    '{K_LK,  32'h0A010203,  6'd0, 8'h00, 1'b1, 8'h02},
    '{K_LK,  32'h0A020000,  6'd0, 8'h00, 1'b1, 8'h01},
    '{K_LK,  32'h0B000000,  6'd0, 8'h00, 1'b0, 8'h00},
    '{K_INS, 32'h00000000,  6'd0, 8'h09, 1'b0, 8'h00},
    '{K_LK,  32'h0B000000,  6'd0, 8'h00, 1'b1, 8'h09},
    '{K_LK,  32'h0A0100FF,  6'd0, 8'h00, 1'b1, 8'h02},
    '{K_DEL, 32'h0A010000, 6'd16, 8'h00, 1'b0, 8'h00},
    '{K_LK,  32'h0A010203,  6'd0, 8'h00, 1'b1, 8'h01},
    '{K_INS, 32'hC0A80101, 6'd32, 8'h07, 1'b0, 8'h00},
    '{K_LK,  32'hC0A80101,  6'd0, 8'h00, 1'b1, 8'h07},
    '{K_LK,  32'hC0A80100,  6'd0, 8'h00, 1'b1, 8'h09},
    '{K_DEL, 32'h0A000000,  6'd8, 8'h00, 1'b0, 8'h00},
    '{K_LK,  32'h0A010203,  6'd0, 8'h00, 1'b1, 8'h09},
    '{K_DEL, 32'h0A000000,  6'd8, 8'h00, 1'b0, 8'h00},
    '{K_LK,  32'h0A000000,  6'd0, 8'h00, 1'b1, 8'h09},
    '{K_INS, 32'h0A000000,  6'd8, 8'h03, 1'b0, 8'h00},
    '{K_LK,  32'h0A7F0000,  6'd0, 8'h00, 1'b1, 8'h03},
    '{K_INS, 32'h0A000000,  6'd8, 8'h05, 1'b0, 8'h00},
    '{K_LK,  32'h0A000000,  6'd0, 8'h00, 1'b1, 8'h05}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0, lk_ready;
  logic [KEY_W-1:0] lk_addr = '0;
  logic             res_valid, res_ready = 1'b1, res_hit;
  logic [NH_W-1:0]  res_nh;
  logic             upd_valid = 1'b0, upd_ready, upd_op = 1'b0;
  logic [KEY_W-1:0] upd_prefix = '0;
  logic [DEP_W-1:0] upd_len = '0;
  logic [NH_W-1:0]  upd_nh = '0;
  logic             upd_done, upd_err;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trie_lpm_engine i_trie_lpm_engine (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_nh(res_nh),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_op(upd_op),
    .upd_prefix(upd_prefix), .upd_len(upd_len), .upd_nh(upd_nh),
    .upd_done(upd_done), .upd_err(upd_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_update(input logic op, input logic [31:0] pfx,
                           input logic [5:0] len, input logic [7:0] nh,
                           output logic err, output int cyc);
    int w;
    @(negedge clk);
    upd_valid = 1'b1; upd_op = op; upd_prefix = pfx; upd_len = len; upd_nh = nh;
    #1;
    w = 0;
    while (!upd_ready && w < 300) begin @(negedge clk); #1; w++; end
    @(posedge clk); #1 upd_valid = 1'b0;
    cyc = 0;
    do begin @(posedge clk); cyc++; @(negedge clk); end while (!upd_done && cyc < 300);
    err = upd_err;
    @(negedge clk);
    chk(!upd_done, "R10", "upd_done single pulse", upd_done, 0);
  endtask

  task automatic do_lookup(input logic [31:0] a, input int hold,
                           output logic h, output logic [7:0] n, output int cyc);
    int w;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    #1;
    w = 0;
    while (!lk_ready && w < 300) begin @(negedge clk); #1; w++; end
    @(posedge clk); #1 lk_valid = 1'b0;
    cyc = 0;
    do begin @(posedge clk); cyc++; @(negedge clk); end while (!res_valid && cyc < 300);
    h = res_hit; n = res_nh;
    if (hold > 0) begin
      res_ready = 1'b0;
      for (int i = 0; i < hold; i++) begin
        @(posedge clk); @(negedge clk);
        chk(res_valid && res_hit == h && res_nh == n, "R2", "result held under stall",
            {res_valid, res_hit, res_nh}, {1'b1, h, n});
        chk(!lk_ready && !upd_ready, "R2", "readies low while result pending",
            {lk_ready, upd_ready}, 0);
      end
      res_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(!res_valid && lk_ready, "R2", "result taken after res_ready",
          {res_valid, lk_ready}, 1);
    end else begin
      @(posedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic h, e;
    logic [7:0] n;
    int cyc;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lk_ready && upd_ready && !res_valid && !upd_done, "R1", "reset outputs",
        {lk_ready, upd_ready, res_valid, upd_done}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R9: empty table misses after one walk cycle
    do_lookup(32'h12345678, 0, h, n, cyc);
    chk(!h && n == 0, "R1", "empty table miss", {h, n}, 0);
    chk(cyc == 1, "R9", "empty lookup latency", cyc, 1);

    // Vector table: R3 R4 R5 R6 R7, with R9 update latency len+1
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].kind == K_LK) begin
        do_lookup(VEC[v].addr, 0, h, n, cyc);
        chk(h == VEC[v].ehit && n == VEC[v].enh,
            VEC[v].ehit ? "R3" : "R4", $sformatf("vector %0d lookup", v),
            {h, n}, {VEC[v].ehit, VEC[v].enh});
      end else begin
        do_update(VEC[v].kind == K_DEL, VEC[v].addr, VEC[v].len, VEC[v].nh, e, cyc);
        chk(!e, VEC[v].kind == K_DEL ? "R6" : "R5", $sformatf("vector %0d no error", v), e, 0);
        chk(cyc == int'(VEC[v].len) + 1, "R9", $sformatf("vector %0d update latency", v),
            cyc, int'(VEC[v].len) + 1);
      end
    end

    // R7 and R9: full-depth path takes 33 cycles
    do_lookup(32'hC0A80101, 0, h, n, cyc);
    chk(h && n == 8'h07, "R7", "/32 match", {h, n}, 9'h107);
    chk(cyc == 33, "R9", "depth-32 lookup latency", cyc, 33);

    // R8: the last 15 free nodes exactly fit this insert
    do_update(1'b0, 32'h80000000, 6'd16, 8'h44, e, cyc);
    chk(!e, "R8", "insert filling pool", e, 0);
    chk(cyc == 17, "R9", "pool-filling insert latency", cyc, 17);
    do_update(1'b0, 32'h40000000, 6'd2, 8'h66, e, cyc);
    chk(e, "R8", "overflow error", e, 1);
    chk(cyc == 2, "R8", "overflow ends at failing depth", cyc, 2);
    do_lookup(32'h40000000, 0, h, n, cyc);
    chk(h && n == 8'h09, "R8", "failed prefix not matchable", {h, n}, 9'h109);
    do_lookup(32'h80000000, 0, h, n, cyc);
    chk(h && n == 8'h44, "R8", "last fitting prefix", {h, n}, 9'h144);
    do_lookup(32'h0A000000, 0, h, n, cyc);
    chk(h && n == 8'h05, "R8", "earlier prefix kept", {h, n}, 9'h105);

    // R6: deleting an absent prefix leaves results alone
    do_update(1'b1, 32'hFF000000, 6'd8, 8'h00, e, cyc);
    do_lookup(32'hFF000001, 0, h, n, cyc);
    chk(h && n == 8'h09, "R6", "absent delete no effect", {h, n}, 9'h109);

    // R2: back-pressure on the result
    do_lookup(32'h0A010203, 3, h, n, cyc);
    chk(h && n == 8'h05, "R2", "stalled lookup value", {h, n}, 9'h105);

    // R2: update wins over a simultaneous lookup
    @(negedge clk);
    lk_valid = 1'b1; upd_valid = 1'b1; upd_op = 1'b1; upd_prefix = '0; upd_len = 6'd32;
    #1;
    chk(!lk_ready && upd_ready, "R2", "update precedence", {lk_ready, upd_ready}, 2'b01);
    lk_valid = 1'b0; upd_valid = 1'b0;

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule